// File: doc/BRIEF.md
# Multiplexed DRAM Address and Cycle Decoder

This block sits between the strobe pins of a 256K-word by 16-bit video DRAM and the logic that models the array or moves rows into the serial register. It samples the active-low row strobe, the two active-low byte column strobes, the address bus and the control levels with a fast system clock. A two-flop synchronizer brings them into the clock domain, and edges are found on the synchronized values.

A falling row strobe opens a cycle. At that edge the block latches a 9-bit row and freezes the write-enable, transfer-enable, column-strobe and special-function levels. From these it decodes the cycle as DRAM read, DRAM write or transfer. The first falling edge of either column strobe then latches a 9-bit column and emits a one-cycle start strobe toward the consumer. While a DRAM cycle is open, the live column strobes drive the per-byte enables and the read data-output enable. A rising row strobe closes the cycle, clears every latched value and pulses done for one cycle.

All inputs pass through the same synchronizer. The address and control levels therefore stay aligned with the strobe edges that sample them. Every output is registered and changes on the third clock edge after an input change.

Top module: `vram_addr_decoder`

## Requirements
- R1: After reset, row, column, word address, cycle type, column-valid, early-column, byte enables, output enable, special-function flags, start and done are all zero.
- R2: A falling row strobe while idle latches the address as the row and raises the cycle-active output. The row holds until the cycle ends.
- R3: Cycle type is coded 0 idle, 1 DRAM read, 2 DRAM write, 3 transfer. A low transfer enable at the row fall gives 3 whatever the write enable is. Otherwise a low write enable gives 2 and a high one gives 1.
- R4: In an open cycle, the first falling edge of either column strobe latches the address as the column, raises column-valid and pulses start for exactly one cycle. A simultaneous fall of both strobes counts as one capture.
- R5: A later column-strobe fall in the same cycle neither changes the latched column nor pulses start again.
- R6: A column-strobe fall while the row strobe is high captures nothing and leaves column-valid low.
- R7: In read or write cycles with a column captured, byte enable bit 0 is high while the lower strobe is low and bit 1 is high while the upper strobe is low. Both bits are zero in transfer cycles and when idle.
- R8: The data-output enable is high only in read cycles with a column captured and at least one column strobe low.
- R9: The special-function level is latched at the row fall into one flag and at the column capture into another.
- R10: The 18-bit word address is the row in bits 17:9 and the column in bits 8:0.
- R11: A rising row strobe ends the cycle. All latched outputs return to zero and done pulses high for exactly one cycle.
- R12: If either column strobe is already low at the row fall, the early-column flag is set for the cycle. No column is captured until a column strobe falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the strobes |
| rst_ni | input | 1 | Asynchronous active-low reset |
| row_stb_ni | input | 1 | Row strobe, active low |
| col_lo_stb_ni | input | 1 | Lower-byte column strobe, active low |
| col_hi_stb_ni | input | 1 | Upper-byte column strobe, active low |
| addr_i | input | 9 | Multiplexed row/column address |
| wr_en_ni | input | 1 | Write enable, active low |
| xfer_en_ni | input | 1 | Transfer enable, active low |
| sf_i | input | 1 | Special-function level |
| row_o | output | 9 | Latched row |
| col_o | output | 9 | Latched column |
| word_addr_o | output | 18 | Row and column combined |
| cyc_active_o | output | 1 | Cycle open |
| cyc_type_o | output | 2 | Cycle type code |
| col_valid_o | output | 1 | Column captured |
| early_col_o | output | 1 | Column strobe was low at row fall |
| byte_en_o | output | 2 | Byte enables {upper, lower} |
| dq_oe_o | output | 1 | Data output enable |
| sf_row_o | output | 1 | Special-function level at row fall |
| sf_col_o | output | 1 | Special-function level at column capture |
| start_o | output | 1 | One-cycle pulse on column capture |
| done_o | output | 1 | One-cycle pulse on cycle end |

## Verification
A stale capture flag shows at the ports at once. A strobe that falls a second time would then change col_o or pulse start_o again, and this is visible three clocks after the strobe moves. A wrong frozen cycle type flips byte_en_o or dq_oe_o on the next column strobe. A cycle that is not cleared at the end leaves row_o, cyc_type_o or col_valid_o nonzero one clock after done_o, and it blocks the next row capture. Each scenario samples the ports a fixed three to four clocks after every stimulus change, so a fault of this kind is reported within the same scenario.

// File: rtl/vad_pkg.sv
package vad_pkg;
  localparam int ADDR_W = 9;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_XFER  = 2'd3
  } cyc_e;

  // transfer enable dominates write enable
  function automatic cyc_e decode_cyc(input logic we_n, input logic xfer_n);
    if (!xfer_n)   return CYC_XFER;
    else if (!we_n) return CYC_WRITE;
    else            return CYC_READ;
  endfunction
endpackage

// File: rtl/vad_sync.sv
module vad_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else         stage_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else         stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/vad_edge.sv
// Flags a high-to-low transition on each bit of a synchronized vector.
module vad_edge #(
  parameter int           W    = 1,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= IDLE;
    else         prev_q <= lvl_i;

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/vad_capture.sv
module vad_capture
  import vad_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          col_lo_ni,
  input  logic          col_hi_ni,
  input  logic          we_ni,
  input  logic          xfer_ni,
  input  logic          sf_i,
  input  logic          row_fall_i,
  input  logic          row_rise_i,
  input  logic [1:0]    col_fall_i,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic          active_o,
  output cyc_e          cyc_o,
  output logic          col_valid_o,
  output logic          early_o,
  output logic [1:0]    byte_en_o,
  output logic          dq_oe_o,
  output logic          sf_row_o,
  output logic          sf_col_o,
  output logic          start_o,
  output logic          done_o
);
  logic [AW-1:0] row_q, col_q;
  logic          active_q, col_valid_q, early_q, sf_row_q, sf_col_q, start_q, done_q, oe_q;
  logic [1:0]    be_q;
  cyc_e          cyc_q;

  logic          end_now, open_now, cap_now, dram_cyc, col_live;
  logic [1:0]    be_d;

  assign end_now  = active_q && row_rise_i;
  assign open_now = !active_q && row_fall_i;
  assign cap_now  = active_q && !col_valid_q && !row_rise_i && (|col_fall_i);
  assign dram_cyc = (cyc_q == CYC_READ) || (cyc_q == CYC_WRITE);
  assign col_live = active_q && !end_now && (col_valid_q || cap_now);
  assign be_d     = (col_live && dram_cyc) ? {~col_hi_ni, ~col_lo_ni} : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0; col_q <= '0; active_q <= 1'b0; cyc_q <= CYC_IDLE;
      col_valid_q <= 1'b0; early_q <= 1'b0; sf_row_q <= 1'b0; sf_col_q <= 1'b0;
      start_q <= 1'b0; done_q <= 1'b0; be_q <= '0; oe_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      be_q    <= be_d;
      oe_q    <= (cyc_q == CYC_READ) && (|be_d);
      if (end_now) begin
        row_q <= '0; col_q <= '0; active_q <= 1'b0; cyc_q <= CYC_IDLE;
        col_valid_q <= 1'b0; early_q <= 1'b0; sf_row_q <= 1'b0; sf_col_q <= 1'b0;
        done_q <= 1'b1;
      end else if (open_now) begin
        row_q    <= addr_i;
        active_q <= 1'b1;
        cyc_q    <= decode_cyc(we_ni, xfer_ni);
        early_q  <= ~col_lo_ni | ~col_hi_ni;
        sf_row_q <= sf_i;
      end else if (cap_now) begin
        col_q       <= addr_i;
        col_valid_q <= 1'b1;
        sf_col_q    <= sf_i;
        start_q     <= 1'b1;
      end
    end
  end

  assign row_o       = row_q;
  assign col_o       = col_q;
  assign active_o    = active_q;
  assign cyc_o       = cyc_q;
  assign col_valid_o = col_valid_q;
  assign early_o     = early_q;
  assign byte_en_o   = be_q;
  assign dq_oe_o     = oe_q;
  assign sf_row_o    = sf_row_q;
  assign sf_col_o    = sf_col_q;
  assign start_o     = start_q;
  assign done_o      = done_q;

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!active_q && !col_valid_q && row_q == '0));
  a_r4_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
  a_r5_col_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_q && !row_rise_i) |=> $stable(col_q));
  a_r2_row_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !row_rise_i) |=> $stable(row_q));
  a_r8_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_q_chk);
  a_r7_be_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q || cyc_q == CYC_XFER) |-> (be_q == 2'b00));
  a_r6_no_col_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !col_valid_q);

  logic dq_oe_q_chk;
  assign dq_oe_q_chk = !oe_q || (cyc_q == CYC_READ && col_valid_q);
endmodule

// File: rtl/vram_addr_decoder.sv
module vram_addr_decoder
  import vad_pkg::*;
#(
  parameter int ADDR_W_P    = ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  row_stb_ni,
  input  logic                  col_lo_stb_ni,
  input  logic                  col_hi_stb_ni,
  input  logic [ADDR_W_P-1:0]   addr_i,
  input  logic                  wr_en_ni,
  input  logic                  xfer_en_ni,
  input  logic                  sf_i,
  output logic [ADDR_W_P-1:0]   row_o,
  output logic [ADDR_W_P-1:0]   col_o,
  output logic [2*ADDR_W_P-1:0] word_addr_o,
  output logic                  cyc_active_o,
  output logic [1:0]            cyc_type_o,
  output logic                  col_valid_o,
  output logic                  early_col_o,
  output logic [1:0]            byte_en_o,
  output logic                  dq_oe_o,
  output logic                  sf_row_o,
  output logic                  sf_col_o,
  output logic                  start_o,
  output logic                  done_o
);
  localparam int CTL_W = 6;
  localparam int BUS_W = CTL_W + ADDR_W_P;
  localparam logic [BUS_W-1:0] BUS_IDLE = {{ADDR_W_P{1'b0}}, 6'b011111};

  logic [BUS_W-1:0]    raw_bus, syn_bus;
  logic                s_row_n, s_lo_n, s_hi_n, s_we_n, s_xfer_n, s_sf;
  logic [ADDR_W_P-1:0] s_addr;
  logic [3:0]          fall;
  cyc_e                cyc;

  // bit order: addr, sf, xfer, we, col_hi, col_lo, row
  assign raw_bus = {addr_i, sf_i, xfer_en_ni, wr_en_ni, col_hi_stb_ni, col_lo_stb_ni, row_stb_ni};

  vad_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_bus),
    .q_o   (syn_bus)
  );

  assign {s_addr, s_sf, s_xfer_n, s_we_n, s_hi_n, s_lo_n, s_row_n} = syn_bus;

  // bit 3 watches the inverted row strobe so its "fall" is the row rise
  vad_edge #(.W(4), .IDLE(4'b0111)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i ({~s_row_n, s_hi_n, s_lo_n, s_row_n}),
    .fall_o(fall)
  );

  vad_capture #(.AW(ADDR_W_P)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (s_addr),
    .col_lo_ni  (s_lo_n),
    .col_hi_ni  (s_hi_n),
    .we_ni      (s_we_n),
    .xfer_ni    (s_xfer_n),
    .sf_i       (s_sf),
    .row_fall_i (fall[0]),
    .row_rise_i (fall[3]),
    .col_fall_i (fall[2:1]),
    .row_o      (row_o),
    .col_o      (col_o),
    .active_o   (cyc_active_o),
    .cyc_o      (cyc),
    .col_valid_o(col_valid_o),
    .early_o    (early_col_o),
    .byte_en_o  (byte_en_o),
    .dq_oe_o    (dq_oe_o),
    .sf_row_o   (sf_row_o),
    .sf_col_o   (sf_col_o),
    .start_o    (start_o),
    .done_o     (done_o)
  );

  assign cyc_type_o  = cyc;
  assign word_addr_o = {row_o, col_o};
endmodule

// File: tb/vram_addr_decoder_test.sv
`timescale 1ns/1ps
module vram_addr_decoder_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic row_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1, we_n = 1'b1, xfer_n = 1'b1, sf = 1'b0;
  logic [8:0]  addr = '0;
  logic [8:0]  row_o, col_o;
  logic [17:0] word_addr_o;
  logic        active_o, col_valid_o, early_o, dq_oe_o, sf_row_o, sf_col_o, start_o, done_o;
  logic [1:0]  type_o, be_o;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  vram_addr_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .row_stb_ni(row_n), .col_lo_stb_ni(lo_n),
    .col_hi_stb_ni(hi_n), .addr_i(addr), .wr_en_ni(we_n), .xfer_en_ni(xfer_n),
    .sf_i(sf), .row_o(row_o), .col_o(col_o), .word_addr_o(word_addr_o),
    .cyc_active_o(active_o), .cyc_type_o(type_o), .col_valid_o(col_valid_o),
    .early_col_o(early_o), .byte_en_o(be_o), .dq_oe_o(dq_oe_o),
    .sf_row_o(sf_row_o), .sf_col_o(sf_col_o), .start_o(start_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // waits 5 negedges, returns how many showed start and done high
  task automatic count_pulses(output int n_start, output int n_done);
    n_start = 0; n_done = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (start_o) n_start++;
      if (done_o)  n_done++;
    end
  endtask

  task automatic end_cycle(input string tag);
    int ns, nd;
    row_n = 1'b1; lo_n = 1'b1; hi_n = 1'b1;
    count_pulses(ns, nd);
    chk({"R11 done pulse ", tag}, nd, 1);
    chk("R11 active cleared", active_o, 0);
    chk("R11 row cleared", row_o, 0);
    chk("R11 col cleared", col_o, 0);
    chk("R11 type cleared", type_o, 0);
    chk("R11 col_valid cleared", col_valid_o, 0);
    chk("R11 early cleared", early_o, 0);
    chk("R11 byte en cleared", be_o, 0);
    chk("R11 sf flags cleared", {sf_row_o, sf_col_o}, 0);
    settle();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 row", row_o, 0);
    chk("R1 col", col_o, 0);
    chk("R1 word", word_addr_o, 0);
    chk("R1 misc", {active_o, type_o, col_valid_o, early_o, be_o, dq_oe_o,
                    sf_row_o, sf_col_o, start_o, done_o}, 0);
    rst_ni = 1'b1;
    settle();
  endtask

  task automatic t_read();
    int ns, nd;
    we_n = 1'b1; xfer_n = 1'b1; sf = 1'b1; addr = 9'h1A5; row_n = 1'b0;
    settle();
    chk("R2 row latched", row_o, 9'h1A5);
    chk("R2 active", active_o, 1);
    chk("R3 read type", type_o, 1);
    chk("R9 sf at row", sf_row_o, 1);
    chk("R7 no enables before column", be_o, 0);
    addr = 9'h0C3; sf = 1'b0; lo_n = 1'b0;
    count_pulses(ns, nd);
    chk("R4 start once", ns, 1);
    chk("R4 col latched", col_o, 9'h0C3);
    chk("R4 col valid", col_valid_o, 1);
    chk("R10 word addr", word_addr_o, {9'h1A5, 9'h0C3});
    chk("R9 sf at col", sf_col_o, 0);
    chk("R7 lower byte", be_o, 2'b01);
    chk("R8 read oe", dq_oe_o, 1);
    addr = 9'h155; hi_n = 1'b0;
    count_pulses(ns, nd);
    chk("R5 no second start", ns, 0);
    chk("R5 col kept", col_o, 9'h0C3);
    chk("R7 both bytes", be_o, 2'b11);
    lo_n = 1'b1;
    settle();
    chk("R7 upper only", be_o, 2'b10);
    chk("R8 oe with upper", dq_oe_o, 1);
    hi_n = 1'b1;
    settle();
    chk("R8 oe off with strobes high", dq_oe_o, 0);
    chk("R7 none with strobes high", be_o, 0);
    end_cycle("read");
  endtask

  task automatic t_write();
    we_n = 1'b0; xfer_n = 1'b1; addr = 9'h0FF; row_n = 1'b0;
    settle();
    chk("R3 write type", type_o, 2);
    addr = 9'h1FF; hi_n = 1'b0;
    settle();
    chk("R4 col from upper", col_o, 9'h1FF);
    chk("R7 write upper", be_o, 2'b10);
    chk("R8 no oe on write", dq_oe_o, 0);
    chk("R10 word write", word_addr_o, {9'h0FF, 9'h1FF});
    end_cycle("write");
    we_n = 1'b1;
  endtask

  task automatic t_xfer();
    we_n = 1'b0; xfer_n = 1'b0; addr = 9'h012; row_n = 1'b0;
    settle();
    chk("R3 transfer dominates", type_o, 3);
    addr = 9'h100; lo_n = 1'b0;
    settle();
    chk("R4 transfer col", col_o, 9'h100);
    chk("R7 no enables in transfer", be_o, 0);
    chk("R8 no oe in transfer", dq_oe_o, 0);
    end_cycle("xfer");
    we_n = 1'b1; xfer_n = 1'b1;
  endtask

  task automatic t_col_no_row();
    int ns, nd;
    addr = 9'h077; lo_n = 1'b0;
    count_pulses(ns, nd);
    chk("R6 no start idle", ns, 0);
    chk("R6 no col idle", col_valid_o, 0);
    chk("R6 col stays zero", col_o, 0);
    chk("R7 no enables idle", be_o, 0);
    lo_n = 1'b1;
    settle();
  endtask

  task automatic t_simul();
    int ns, nd;
    addr = 9'h003; row_n = 1'b0;
    settle();
    addr = 9'h0AA; lo_n = 1'b0; hi_n = 1'b0;
    count_pulses(ns, nd);
    chk("R4 simultaneous one start", ns, 1);
    chk("R4 simultaneous col", col_o, 9'h0AA);
    chk("R7 simultaneous bytes", be_o, 2'b11);
    end_cycle("simul");
  endtask

  task automatic t_early();
    lo_n = 1'b0;
    settle();
    addr = 9'h044; row_n = 1'b0;
    settle();
    chk("R12 early flag", early_o, 1);
    chk("R12 no col yet", col_valid_o, 0);
    lo_n = 1'b1;
    settle();
    addr = 9'h033; lo_n = 1'b0;
    settle();
    chk("R12 col after refall", col_o, 9'h033);
    chk("R12 valid after refall", col_valid_o, 1);
    chk("R12 early held", early_o, 1);
    end_cycle("early");
  endtask

  initial begin
    t_reset();
    t_read();
    t_write();
    t_xfer();
    t_col_no_row();
    t_simul();
    t_early();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 100000);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule